// File: doc/BRIEF.md
# DMA Channel Interrupt and Control Register Bank

This block is the software-visible register file of a multi-channel DMA engine. It collects per-channel completion, termination and bus-error events into sticky flags. It combines those flags with per-channel enables into one interrupt line per channel. It also holds the controls that software uses to steer each channel: freeze, a deferred channel reset, a next-descriptor pointer and a semaphore counter. The channel datapaths sit outside the block. They send event pulses and a 4-bit state code in, and they receive the freeze, reset, descriptor and semaphore outputs.

Every global register and every next-descriptor register has three write addresses. A write at the base address overwrites the register. A write at base+4 ORs the written ones into it. A write at base+8 clears the bits that are written as ones. Software can therefore acknowledge one channel's interrupt without touching the others. Per-channel registers repeat at a 0x70-byte stride. The semaphore register accumulates: a write adds the written value to the count.

Top module: `dma_irq_regbank`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `irq`, `freeze`, `ch_reset`, `sem_ready`, `nxt_desc`, `burst_en` and `burst8_en` are all 0.
- R2: A read request loads `bus_rdata` at the next clock edge, and `bus_rdata` holds that value until the next read. A read of an unmapped address returns 0.
- R3: For the registers at 0x000, 0x010, 0x020, 0x030 and every next-descriptor register, a write at base+0 replaces the implemented bits, a write at base+4 sets the written ones, and a write at base+8 clears the written ones. A read at any of the three addresses returns the register.
- R4: Register 0x000 implements only bit 28, which drives `burst_en`, and bit 29, which drives `burst8_en`. All other bits read 0.
- R5: A pulse on `ev_done[n]` sets bit n of register 0x010. When the pulse arrives in the same cycle as a software clear of that bit, the set wins.
- R6: `irq[n]` is high when bit n of 0x010 and enable bit n+16 of 0x010 are both 1, or when bit n of 0x020 is 1.
- R7: `ev_term[n]` sets bit n of 0x020. `ev_buserr[n]` sets both bit n and bit n+16. The error code bit(n+16)+bit(n) is therefore 1 for a termination and 2 for a bus error.
- R8: Bits n of register 0x030 drive `freeze[n]`.
- R9: Setting bit n+16 of 0x030 requests a reset of channel n. While the channel's state nibble `ch_state[4n+3:4n]` equals 0x8, the request stays pending and `ch_reset[n]` stays low. In any other state, `ch_reset[n]` is high for exactly one cycle and the bit clears itself.
- R10: The next-descriptor register of channel n sits at 0x110+n*0x70 and drives `nxt_desc[32n+31:32n]`.
- R11: The semaphore of channel n sits at 0x140+n*0x70. A write there adds the low SEM_W bits of the data, and the sum saturates at 2^SEM_W-1. A `sem_take[n]` pulse subtracts 1 when the count (plus any same-cycle add) is nonzero. Writes to its +4 and +8 addresses are ignored. `sem_ready[n]` is high while the count is nonzero.
- R12: Address 0x130+n*0x70 reads the channel's live `ch_bufaddr` lane. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| ev_done | input | NCH | Per-channel completion pulses |
| ev_term | input | NCH | Per-channel termination pulses |
| ev_buserr | input | NCH | Per-channel bus-error pulses |
| sem_take | input | NCH | Per-channel semaphore decrement pulses |
| ch_state | input | 4*NCH | Per-channel state code, 4 bits per channel |
| ch_bufaddr | input | 32*NCH | Per-channel current buffer address |
| irq | output | NCH | Per-channel interrupt lines |
| freeze | output | NCH | Per-channel freeze controls |
| ch_reset | output | NCH | One-cycle channel reset pulses |
| sem_ready | output | NCH | Semaphore count nonzero |
| nxt_desc | output | 32*NCH | Per-channel next-descriptor pointers |
| burst_en | output | 1 | Burst enable |
| burst8_en | output | 1 | 8-beat burst enable |

## Verification
The event-to-flag-to-interrupt path is swept over every channel, both with its enable set and with it cleared. This separates a flag that fails to latch from an enable that fails to gate. Each channel also gets a termination and a bus-error event, which show apart the two halves of the error register and the two error codes. The freeze field is driven with all sixteen patterns of a four-channel build, and each channel's reset is requested once inside and once outside the flush state, so deferral and self-clearing are both observed. The semaphore is walked through accumulation, saturation, a combined add-and-take, and draining past zero.

// File: rtl/dma_irq_pkg.sv
`timescale 1ns/1ps
// Shared constants, operation type and helpers for the DMA register bank.
// Assumes a 12-bit byte address and 32-bit data words.
package dma_irq_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int HALF_W = 16;
    localparam int STATE_W = 4;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_DONE  = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_ERR   = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_CHCTL = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_NXT   = 12'h110;
    localparam logic [ADDR_W-1:0] OFF_BAR   = 12'h130;
    localparam logic [ADDR_W-1:0] OFF_SEM   = 12'h140;
    localparam logic [ADDR_W-1:0] CH_STRIDE = 12'h070;
    localparam logic [ADDR_W-1:0] ALIAS_SET = 12'h004;
    localparam logic [ADDR_W-1:0] ALIAS_CLR = 12'h008;

    localparam int BIT_BURST  = 28;
    localparam int BIT_BURST8 = 29;

    localparam logic [STATE_W-1:0] ST_RDFLUSH = 4'h8;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_WRITE,
        OP_SET,
        OP_CLEAR
    } reg_op_t;

    // Classify a write against a register with set and clear aliases.
    function automatic reg_op_t decode_op(input logic wr,
                                          input logic [ADDR_W-1:0] addr,
                                          input logic [ADDR_W-1:0] base);
        reg_op_t op;
        op = OP_NONE;
        if (wr) begin
            if (addr == base)                        op = OP_WRITE;
            else if (addr == base + ALIAS_SET)       op = OP_SET;
            else if (addr == base + ALIAS_CLR)       op = OP_CLEAR;
        end
        return op;
    endfunction

    // True when addr is the base or one of its two aliases.
    function automatic logic in_block(input logic [ADDR_W-1:0] addr,
                                      input logic [ADDR_W-1:0] base);
        return (addr == base) || (addr == base + ALIAS_SET) ||
               (addr == base + ALIAS_CLR);
    endfunction

    // Next register value for one write operation.
    function automatic logic [DATA_W-1:0] apply_op(input reg_op_t op,
                                                   input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] wdata);
        logic [DATA_W-1:0] nxt;
        case (op)
            OP_WRITE: nxt = wdata;
            OP_SET:   nxt = cur | wdata;
            OP_CLEAR: nxt = cur & ~wdata;
            default:  nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/dma_irq_glob_regs.sv
`timescale 1ns/1ps
// Global registers: burst control, completion flags and enables,
// error flags, and per-channel freeze and deferred reset.
// Assumes NCH <= 16. Hardware event sets take priority over software clears.
module dma_irq_glob_regs
    import dma_irq_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    input  logic [NCH-1:0]          ev_done,
    input  logic [NCH-1:0]          ev_term,
    input  logic [NCH-1:0]          ev_buserr,
    input  logic [STATE_W*NCH-1:0]  ch_state,
    output logic [DATA_W-1:0]       ctrl_q,
    output logic [DATA_W-1:0]       done_q,
    output logic [DATA_W-1:0]       err_q,
    output logic [DATA_W-1:0]       chctl_q,
    output logic [NCH-1:0]          rst_apply
);

    localparam logic [63:0]       LANE64    = (64'd1 << NCH) - 64'd1;
    localparam logic [DATA_W-1:0] LANE_MASK = LANE64[DATA_W-1:0];
    localparam logic [DATA_W-1:0] PAIR_MASK = LANE_MASK | (LANE_MASK << HALF_W);
    localparam logic [DATA_W-1:0] CTRL_MASK = (DATA_W'(1) << BIT_BURST) |
                                              (DATA_W'(1) << BIT_BURST8);

    reg_op_t           ctrl_op, done_op, err_op, chctl_op;
    logic [DATA_W-1:0] done_ev, term_ev, berr_ev, apply_hi;

    // Decode which global register, if any, the current write targets.
    always_comb begin : p_decode
        ctrl_op  = decode_op(bus_wr, bus_addr, OFF_CTRL);
        done_op  = decode_op(bus_wr, bus_addr, OFF_DONE);
        err_op   = decode_op(bus_wr, bus_addr, OFF_ERR);
        chctl_op = decode_op(bus_wr, bus_addr, OFF_CHCTL);
    end

    // Widen event and reset-apply vectors to register width.
    always_comb begin : p_events
        done_ev  = DATA_W'(ev_done);
        term_ev  = DATA_W'(ev_term);
        berr_ev  = DATA_W'(ev_buserr);
        apply_hi = DATA_W'(rst_apply) << HALF_W;
    end

    // A pending reset is applied only outside the read-flush state.
    for (genvar c = 0; c < NCH; c++) begin : g_apply
        assign rst_apply[c] = chctl_q[HALF_W + c] &&
                              (ch_state[STATE_W*c +: STATE_W] != ST_RDFLUSH);
    end

    // Register update: software operation, then hardware sets and self-clears.
    always_ff @(posedge clk) begin : p_regs
        if (!rst_n) begin
            ctrl_q  <= '0;
            done_q  <= '0;
            err_q   <= '0;
            chctl_q <= '0;
        end else begin
            ctrl_q  <= apply_op(ctrl_op, ctrl_q, bus_wdata) & CTRL_MASK;
            done_q  <= (apply_op(done_op, done_q, bus_wdata) | done_ev) & PAIR_MASK;
            err_q   <= (apply_op(err_op, err_q, bus_wdata) | term_ev | berr_ev |
                        (berr_ev << HALF_W)) & PAIR_MASK;
            chctl_q <= apply_op(chctl_op, chctl_q, bus_wdata) & PAIR_MASK & ~apply_hi;
        end
    end

endmodule

// File: rtl/dma_irq_chan_slice.sv
`timescale 1ns/1ps
// One channel's registers: next-descriptor pointer (with aliases),
// accumulating saturating semaphore, and read-only buffer address view.
// Assumes CH * CH_STRIDE + OFF_SEM fits in the 12-bit address.
module dma_irq_chan_slice
    import dma_irq_pkg::*;
#(
    parameter int CH    = 0,
    parameter int SEM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              sem_take,
    input  logic [DATA_W-1:0] bufaddr,
    output logic [DATA_W-1:0] nxt_desc,
    output logic              sem_ready,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_word
);

    localparam int NXT_I = int'(OFF_NXT) + CH * int'(CH_STRIDE);
    localparam int BAR_I = int'(OFF_BAR) + CH * int'(CH_STRIDE);
    localparam int SEM_I = int'(OFF_SEM) + CH * int'(CH_STRIDE);
    localparam logic [ADDR_W-1:0] NXT_ADDR = NXT_I[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] BAR_ADDR = BAR_I[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] SEM_ADDR = SEM_I[ADDR_W-1:0];

    reg_op_t          nxt_op;
    logic             sem_wr;
    logic [SEM_W-1:0] sem_cnt;
    logic [SEM_W:0]   sem_sum, sem_after;

    // Write decode for this channel's registers.
    always_comb begin : p_decode
        nxt_op = decode_op(bus_wr, bus_addr, NXT_ADDR);
        sem_wr = bus_wr && (bus_addr == SEM_ADDR);
    end

    // Semaphore arithmetic: add written value, then take one if nonzero.
    always_comb begin : p_sem_next
        sem_sum   = {1'b0, sem_cnt} +
                    (sem_wr ? {1'b0, bus_wdata[SEM_W-1:0]} : '0);
        sem_after = (sem_take && (sem_sum != '0)) ?
                    sem_sum - (SEM_W+1)'(1) : sem_sum;
    end

    // Descriptor pointer and saturating semaphore registers.
    always_ff @(posedge clk) begin : p_regs
        if (!rst_n) begin
            nxt_desc <= '0;
            sem_cnt  <= '0;
        end else begin
            nxt_desc <= apply_op(nxt_op, nxt_desc, bus_wdata);
            sem_cnt  <= sem_after[SEM_W] ? '1 : sem_after[SEM_W-1:0];
        end
    end

    assign sem_ready = (sem_cnt != '0);

    // Read view of this channel's three registers.
    always_comb begin : p_read
        rd_hit  = 1'b1;
        if (in_block(bus_addr, NXT_ADDR))  rd_word = nxt_desc;
        else if (bus_addr == BAR_ADDR)     rd_word = bufaddr;
        else if (bus_addr == SEM_ADDR)     rd_word = DATA_W'(sem_cnt);
        else begin
            rd_hit  = 1'b0;
            rd_word = '0;
        end
    end

endmodule

// File: rtl/dma_irq_regbank.sv
`timescale 1ns/1ps
// Top of the DMA interrupt and control register bank. Combines global
// registers with NCH channel slices, forms per-channel interrupts and
// registers read data one cycle after a read strobe.
// Assumes 1 <= NCH <= 16 and one access per cycle.
module dma_irq_regbank
    import dma_irq_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int SEM_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [11:0]              bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NCH-1:0]           ev_done,
    input  logic [NCH-1:0]           ev_term,
    input  logic [NCH-1:0]           ev_buserr,
    input  logic [NCH-1:0]           sem_take,
    input  logic [4*NCH-1:0]         ch_state,
    input  logic [32*NCH-1:0]        ch_bufaddr,
    output logic [NCH-1:0]           irq,
    output logic [NCH-1:0]           freeze,
    output logic [NCH-1:0]           ch_reset,
    output logic [NCH-1:0]           sem_ready,
    output logic [32*NCH-1:0]        nxt_desc,
    output logic                     burst_en,
    output logic                     burst8_en
);

    logic [DATA_W-1:0] ctrl_q, done_q, err_q, chctl_q;
    logic [NCH-1:0]    ch_hit;
    logic [DATA_W-1:0] ch_word [NCH];
    logic [DATA_W-1:0] rd_mux;

    dma_irq_glob_regs #(.NCH(NCH)) glob_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ev_done   (ev_done),
        .ev_term   (ev_term),
        .ev_buserr (ev_buserr),
        .ch_state  (ch_state),
        .ctrl_q    (ctrl_q),
        .done_q    (done_q),
        .err_q     (err_q),
        .chctl_q   (chctl_q),
        .rst_apply (ch_reset)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dma_irq_chan_slice #(.CH(c), .SEM_W(SEM_W)) slice_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_wr    (bus_wr),
            .bus_addr  (bus_addr),
            .bus_wdata (bus_wdata),
            .sem_take  (sem_take[c]),
            .bufaddr   (ch_bufaddr[DATA_W*c +: DATA_W]),
            .nxt_desc  (nxt_desc[DATA_W*c +: DATA_W]),
            .sem_ready (sem_ready[c]),
            .rd_hit    (ch_hit[c]),
            .rd_word   (ch_word[c])
        );
    end

    // Per-channel interrupt: enabled completion or any error flag.
    always_comb begin : p_irq
        irq = (done_q[NCH-1:0] & done_q[HALF_W +: NCH]) | err_q[NCH-1:0];
    end

    assign freeze    = chctl_q[NCH-1:0];
    assign burst_en  = ctrl_q[BIT_BURST];
    assign burst8_en = ctrl_q[BIT_BURST8];

    // Select the addressed register for a read; unmapped returns zero.
    always_comb begin : p_rd_mux
        rd_mux = '0;
        if (in_block(bus_addr, OFF_CTRL))       rd_mux = ctrl_q;
        else if (in_block(bus_addr, OFF_DONE))  rd_mux = done_q;
        else if (in_block(bus_addr, OFF_ERR))   rd_mux = err_q;
        else if (in_block(bus_addr, OFF_CHCTL)) rd_mux = chctl_q;
        else begin
            for (int c = 0; c < NCH; c++) begin
                if (ch_hit[c]) rd_mux = ch_word[c];
            end
        end
    end

    // Capture read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin : p_rdata
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/dma_irq_regbank_chk.sv
`timescale 1ns/1ps
// Property checker for dma_irq_regbank, attached by bind.
// Assumes the same NCH as the bound instance.
module dma_irq_regbank_chk #(
    parameter int NCH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [NCH-1:0]   ev_buserr,
    input logic [NCH-1:0]   irq,
    input logic [NCH-1:0]   ch_reset,
    input logic [4*NCH-1:0] ch_state,
    input logic [NCH-1:0]   sem_take,
    input logic [NCH-1:0]   sem_ready,
    input logic [NCH-1:0]   freeze,
    input logic             burst_en,
    input logic             burst8_en
);

    // A bus error raises the channel interrupt on the next cycle.
    assert_buserr_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_buserr) |=> ((irq & $past(ev_buserr)) == $past(ev_buserr)));

    // A channel reset pulse never lasts two cycles.
    assert_reset_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_reset) |=> ((ch_reset & $past(ch_reset)) == '0));

    // No reset is issued to a channel in the read-flush state.
    for (genvar c = 0; c < NCH; c++) begin : g_flush
        assert_flush_defer_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_state[4*c +: 4] == 4'h8) |-> !ch_reset[c]);
    end

    // Burst controls change only after a write.
    assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable({burst_en, burst8_en}));

    // Freeze controls change only after a write.
    assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(freeze));

    // A semaphore only empties after a take.
    assert_sem_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((~sem_ready & $past(sem_ready) & ~$past(sem_take)) == '0));

endmodule

bind dma_irq_regbank dma_irq_regbank_chk #(.NCH(NCH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .ev_buserr (ev_buserr),
    .irq       (irq),
    .ch_reset  (ch_reset),
    .ch_state  (ch_state),
    .sem_take  (sem_take),
    .sem_ready (sem_ready),
    .freeze    (freeze),
    .burst_en  (burst_en),
    .burst8_en (burst8_en)
);

// File: tb/dma_irq_regbank_tb.sv
`timescale 1ns/1ps
// Self-checking bench for dma_irq_regbank on a four-channel build.
module dma_irq_regbank_tb_top;

    localparam int NCH   = 4;
    localparam int SEM_W = 4;
    localparam int DW    = 32;
    localparam int WDOG  = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    ev_done = '0;
    logic [NCH-1:0]    ev_term = '0;
    logic [NCH-1:0]    ev_buserr = '0;
    logic [NCH-1:0]    sem_take = '0;
    logic [4*NCH-1:0]  ch_state = '0;
    logic [DW*NCH-1:0] ch_bufaddr = '0;
    logic [NCH-1:0]    irq, freeze, ch_reset, sem_ready;
    logic [DW*NCH-1:0] nxt_desc;
    logic              burst_en, burst8_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    dma_irq_regbank #(.NCH(NCH), .SEM_W(SEM_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_done(ev_done), .ev_term(ev_term), .ev_buserr(ev_buserr),
        .sem_take(sem_take), .ch_state(ch_state), .ch_bufaddr(ch_bufaddr),
        .irq(irq), .freeze(freeze), .ch_reset(ch_reset), .sem_ready(sem_ready),
        .nxt_desc(nxt_desc), .burst_en(burst_en), .burst8_en(burst8_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [NCH-1:0] d, input logic [NCH-1:0] t,
                         input logic [NCH-1:0] b, input logic [NCH-1:0] s);
        @(negedge clk);
        ev_done = d; ev_term = t; ev_buserr = b; sem_take = s;
        @(negedge clk);
        ev_done = '0; ev_term = '0; ev_buserr = '0; sem_take = '0;
    endtask

    function automatic logic [11:0] ch_addr(input logic [11:0] base, input int n);
        return base + 12'(n * 'h70);
    endfunction

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        for (int n = 0; n < NCH; n++) ch_bufaddr[DW*n +: DW] = 32'hB000_0000 + 32'(n * 'h111);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 freeze", 32'(freeze), 0);
        check("R1 ch_reset", 32'(ch_reset), 0);
        check("R1 sem_ready", 32'(sem_ready), 0);
        check("R1 burst", {30'd0, burst8_en, burst_en}, 0);
        check("R1 nxt_desc lane0", nxt_desc[31:0], 0);
        check("R1 rdata", bus_rdata, 0);
        do_read(12'h010, r); check("R1 done reg", r, 0);
        do_read(12'h030, r); check("R1 chctl reg", r, 0);

        // R4 and R3: control register, implemented bits and aliases
        do_write(12'h000, 32'hFFFF_FFFF);
        do_read(12'h000, r); check("R4 ctrl implemented bits", r, 32'h3000_0000);
        check("R4 burst outputs", {30'd0, burst8_en, burst_en}, 32'h3);
        do_write(12'h008, 32'h1000_0000);
        do_read(12'h004, r); check("R3 ctrl clear alias", r, 32'h2000_0000);
        check("R4 burst_en cleared", {30'd0, burst8_en, burst_en}, 32'h2);
        do_write(12'h000, 32'h0);

        // R3: completion register aliases
        do_write(12'h010, 32'h000F_0000);
        do_read(12'h010, r); check("R3 plain write", r, 32'h000F_0000);
        do_write(12'h014, 32'h0000_0003);
        do_read(12'h010, r); check("R3 set alias", r, 32'h000F_0003);
        do_write(12'h018, 32'h0005_0003);
        do_read(12'h018, r); check("R3 clear alias", r, 32'h000A_0000);
        do_write(12'h010, 32'h000F_0000);

        // R5, R6: completion flags and enables per channel
        for (int n = 0; n < NCH; n++) begin
            pulse(4'(1 << n), '0, '0, '0);
            do_read(12'h010, r); check("R5 flag set", r, 32'h000F_0000 | (32'h1 << n));
            check("R6 irq enabled", 32'(irq), 32'h1 << n);
            do_write(12'h018, 32'h1 << n);
            check("R6 irq after clear", 32'(irq), 0);
            do_write(12'h018, 32'h1 << (16 + n));
            pulse(4'(1 << n), '0, '0, '0);
            check("R6 irq masked", 32'(irq), 0);
            do_read(12'h010, r);
            check("R5 masked flag", r, (32'h000F_0000 & ~(32'h1 << (16 + n))) | (32'h1 << n));
            do_write(12'h014, 32'h1 << (16 + n));
            check("R6 irq on enable", 32'(irq), 32'h1 << n);
            do_write(12'h018, 32'h1 << n);
        end

        // R5: hardware set beats a same-cycle software clear
        @(negedge clk);
        ev_done = 4'b0001; bus_wr = 1'b1; bus_addr = 12'h018; bus_wdata = 32'h1;
        @(negedge clk);
        ev_done = '0; bus_wr = 1'b0;
        do_read(12'h010, r); check("R5 set priority", r, 32'h000F_0001);
        do_write(12'h018, 32'h1);

        // R7, R6: termination and bus error per channel
        for (int n = 0; n < NCH; n++) begin
            pulse('0, 4'(1 << n), '0, '0);
            do_read(12'h020, r); check("R7 term flag", r, 32'h1 << n);
            check("R7 term code", 32'(r[16 + n]) + 32'(r[n]), 1);
            check("R6 irq on error", 32'(irq), 32'h1 << n);
            do_write(12'h028, 32'h1 << n);
            pulse('0, '0, 4'(1 << n), '0);
            do_read(12'h024, r); check("R7 bus error flags", r, (32'h1 << n) | (32'h1 << (16 + n)));
            check("R7 bus error code", 32'(r[16 + n]) + 32'(r[n]), 2);
            do_write(12'h028, (32'h1 << n) | (32'h1 << (16 + n)));
            do_read(12'h020, r); check("R7 cleared", r, 0);
            check("R6 irq idle", 32'(irq), 0);
        end

        // R8: every freeze pattern
        for (int p = 0; p < 16; p++) begin
            do_write(12'h030, 32'(p));
            check("R8 freeze pattern", 32'(freeze), 32'(p));
        end
        do_write(12'h030, 32'h0);

        // R9: reset deferred in flush state, immediate otherwise
        for (int n = 0; n < NCH; n++) begin
            ch_state[4*n +: 4] = 4'h8;
            do_write(12'h034, 32'h1 << (16 + n));
            check("R9 deferred no pulse", 32'(ch_reset), 0);
            do_read(12'h030, r); check("R9 request pending", r, 32'h1 << (16 + n));
            @(negedge clk);
            ch_state[4*n +: 4] = 4'h0;
            #1;
            check("R9 pulse after flush", 32'(ch_reset), 32'h1 << n);
            @(negedge clk);
            check("R9 pulse ends", 32'(ch_reset), 0);
            do_read(12'h030, r); check("R9 self clear", r, 0);
            ch_state[4*n +: 4] = 4'(7 + 2 * (n % 2));
            do_write(12'h034, 32'h1 << (16 + n));
            check("R9 immediate pulse", 32'(ch_reset), 32'h1 << n);
            @(negedge clk);
            check("R9 immediate ends", 32'(ch_reset), 0);
            ch_state[4*n +: 4] = 4'h0;
        end

        // R10: next-descriptor per channel with aliases
        for (int n = 0; n < NCH; n++) begin
            do_write(ch_addr(12'h110, n), 32'hA000_0000 | 32'(n << 8));
            check("R10 nxt output", nxt_desc[DW*n +: DW], 32'hA000_0000 | 32'(n << 8));
            do_write(ch_addr(12'h114, n), 32'h0000_000F);
            do_write(ch_addr(12'h118, n), 32'h2000_0003);
            do_read(ch_addr(12'h110, n), r);
            check("R10 nxt aliases", r, 32'h8000_000C | 32'(n << 8));
        end

        // R12: buffer address view, writes ignored
        for (int n = 0; n < NCH; n++) begin
            do_write(ch_addr(12'h130, n), 32'h0);
            do_read(ch_addr(12'h130, n), r);
            check("R12 bufaddr view", r, 32'hB000_0000 + 32'(n * 'h111));
        end

        // R11: semaphore accumulation, saturation, take
        do_read(12'h220, r); check("R11 sem initial", r, 0);
        do_write(12'h220, 32'd5);
        do_read(12'h220, r); check("R11 sem add", r, 5);
        check("R11 ready", 32'(sem_ready), 32'h4);
        do_write(12'h220, 32'h17);
        do_read(12'h220, r); check("R11 sem add low bits", r, 12);
        do_write(12'h220, 32'd9);
        do_read(12'h220, r); check("R11 sem saturate", r, 15);
        pulse('0, '0, '0, 4'b0100);
        do_read(12'h220, r); check("R11 sem take", r, 14);
        do_write(12'h224, 32'd3);
        do_write(12'h228, 32'hF);
        do_read(12'h220, r); check("R11 aliases ignored", r, 14);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h220; bus_wdata = 32'd2; sem_take = 4'b0100;
        @(negedge clk);
        bus_wr = 1'b0; sem_take = '0;
        do_read(12'h220, r); check("R11 add and take", r, 15);
        repeat (16) pulse('0, '0, '0, 4'b0100);
        do_read(12'h220, r); check("R11 drain floor", r, 0);
        check("R11 not ready", 32'(sem_ready), 0);

        // R2: unmapped read returns zero, data holds between reads
        do_read(12'h000, r);
        do_read(12'h0FC, r); check("R2 unmapped", r, 0);
        do_read(12'h110, r);
        repeat (3) @(negedge clk);
        check("R2 rdata holds", bus_rdata, 32'h8000_000C);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule